// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Pretimeout

This peripheral guards a system against software that stops running. Software loads a 32-bit watchdog count and enables it; the count then falls toward zero. Regular keepalive writes reload the count. If it ever reaches zero, a sticky expiry flag is set, an expiry interrupt is raised and, if software allowed it, a system reset request is driven. A second 32-bit down-counter runs next to the watchdog. It is loaded with a shorter span, so its interrupt arrives before the watchdog expires and gives software a last warning.

Each counter takes its count tick from one of two sources. The divided source ticks once every 2^ratio clocks, where ratio is a control field. The fixed source is an external reference strobe, `fix_tick`, which ignores the ratio. Both counters can be read at any time, so software can work out the time left as count divided by tick rate. The reset request passes through two gates: a reset-enable register and a separate mask register. Software accesses everything through a simple 32-bit register bus. Writes take effect on the clock edge. Reads are combinational from the address.

Register map (byte offsets): 0x00 control, 0x04 status, 0x08 pretimeout count, 0x0C watchdog count, 0x10 reset-enable, 0x14 reset-mask. Control fields: bit 0 watchdog run, bit 1 pretimeout run, bit 2 watchdog fixed-source select, bit 3 pretimeout fixed-source select, bits 8:4 ratio. Status: bit 0 expiry flag, bit 1 pretimeout flag.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control, status, reset-enable and reset-mask read 0. Both counters read 0xFFFFFFFF. `expire_irq`, `pretime_irq` and `rst_req` are low.
- R2: A bus write to offset 0x0C (watchdog) or 0x08 (pretimeout) loads that counter on the write edge. A read of the same offset returns the live count at any time.
- R3: A counter changes only while its run bit is set (control bit 0 for the watchdog, bit 1 for the pretimeout). With the divided source and ratio 0, it falls by one on every clock.
- R4: Writing a counter while it runs (a keepalive) restarts the countdown from the written value.
- R5: When the watchdog count is zero while it runs, status bit 0 is set on the next edge. `expire_irq` follows that bit. The count stays at zero until it is reloaded.
- R6: `rst_req` is high only while the expiry flag is set, reset-enable bit 0 is 1, reset-mask bit 0 is 0 and the watchdog run bit is 1.
- R7: A write to status clears each flag whose bit is written 0 and leaves unchanged each flag whose bit is written 1.
- R8: When the pretimeout count is zero while it runs, status bit 1 is set. `pretime_irq` stays high until software clears that flag. The count stays at zero until it is reloaded.
- R9: With the divided source, a counter ticks once every 2^ratio clocks, where ratio is control bits 8:4. For ratio 2 that is 16 decrements in 64 clocks.
- R10: When a counter's fixed-source bit is set (bit 2 for the watchdog, bit 3 for the pretimeout), it decrements once for each clock on which `fix_tick` is high, whatever the ratio. It does not move while `fix_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_tick | input | 1 | Fixed reference tick strobe, one clock wide per tick |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| expire_irq | output | 1 | Watchdog expiry interrupt (level) |
| pretime_irq | output | 1 | Pretimeout warning interrupt (level) |
| rst_req | output | 1 | System reset request |

## Verification
A corrupted counter shows up in the readable count within one tick. It also shows up as an expiry or pretimeout flag that arrives a tick early, a tick late, or never, visible on `expire_irq` or `pretime_irq` one edge after the count sits at zero. A prescaler or source-select fault shows as a decrement total over a fixed window that does not match 2^ratio or the number of `fix_tick` pulses. A stuck gate term in the reset path shows on `rst_req` in the same cycle that the enable, mask or run bit is written.

// File: rtl/wdog_pkg.sv
// Shared definitions for the watchdog timer: register offsets, channel
// indices and the control register layout.
// Assumes byte addressing on an 8-bit register bus address.
package wdog_pkg;
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_STATUS = 8'h04;
    localparam logic [7:0] OFF_PRECNT = 8'h08;
    localparam logic [7:0] OFF_WDCNT  = 8'h0C;
    localparam logic [7:0] OFF_RSTEN  = 8'h10;
    localparam logic [7:0] OFF_RSTMSK = 8'h14;

    localparam int NUM_CH  = 2;
    localparam int CH_WD   = 0;
    localparam int CH_PRE  = 1;
    localparam int RATIO_W = 5;

    // Control register, packed from bit 8 down to bit 0.
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;   // 8:4
        logic               pre_fix; // 3
        logic               wd_fix;  // 2
        logic               pre_run; // 1
        logic               wd_run;  // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wdog_tick_sel.sv
// Tick generator: a free-running prescaler gives a divided tick every
// 2^ratio clocks. Each channel picks either that tick or the external
// fixed-reference strobe.
// Assumes fix_tick is already synchronous to clk.
module wdog_tick_sel #(
    parameter int RATIO_W = 5,
    parameter int NCH     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [NCH-1:0]     fix_sel,
    input  logic               fix_tick,
    output logic [NCH-1:0]     tick
);
    localparam int PRESC_W = 1 << RATIO_W;

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] low_mask;
    logic               div_tick;

    // Free-running prescaler count
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    // Divided tick when the low ratio bits are all ones
    always_comb begin
        low_mask = (PRESC_W'(1) << ratio) - PRESC_W'(1);
        div_tick = (presc_q & low_mask) == low_mask;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign tick[i] = fix_sel[i] ? fix_tick : div_tick;
    end
endmodule

// File: rtl/wdog_countdown.sv
// One loadable down-counter. A load wins over counting. The counter
// falls by one on each tick while running and stops at zero.
// at_zero flags the running-at-zero condition to the status logic.
module wdog_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);
    // Count register: load, decrement on tick, hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '1;
        else if (load)                       cnt <= load_val;
        else if (run && tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign at_zero = run && (cnt == '0);
endmodule

// File: rtl/wdog_timer.sv
// Watchdog timer top: register bus decode, control and status registers,
// the two countdown channels and the gated reset request.
// Assumes single-cycle bus writes and combinational reads.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              expire_irq,
    output logic              pretime_irq,
    output logic              rst_req
);
    ctrl_t             ctrl_q;
    logic [NUM_CH-1:0] flag_q;
    logic              rst_en_q;
    logic              rst_msk_q;

    logic              wr_en;
    logic              ctrl_wr, sts_wr, rsten_wr, rstmsk_wr;
    logic [NUM_CH-1:0] ld, run, fsel, tick, hit;
    logic [DATA_W-1:0] cnt [NUM_CH];

    logic [DATA_W-1:0] wd_count, pre_count;
    logic              wd_run, pre_run, wd_load, pre_load;

    // Write strobes per register
    always_comb begin
        wr_en     = bus_sel && bus_wr;
        ctrl_wr   = wr_en && bus_addr == ADDR_W'(OFF_CTRL);
        sts_wr    = wr_en && bus_addr == ADDR_W'(OFF_STATUS);
        rsten_wr  = wr_en && bus_addr == ADDR_W'(OFF_RSTEN);
        rstmsk_wr = wr_en && bus_addr == ADDR_W'(OFF_RSTMSK);
        ld[CH_WD]  = wr_en && bus_addr == ADDR_W'(OFF_WDCNT);
        ld[CH_PRE] = wr_en && bus_addr == ADDR_W'(OFF_PRECNT);
    end

    // Control and reset-gate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            rst_en_q  <= 1'b0;
            rst_msk_q <= 1'b0;
        end else begin
            if (ctrl_wr)   ctrl_q    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (rsten_wr)  rst_en_q  <= bus_wdata[0];
            if (rstmsk_wr) rst_msk_q <= bus_wdata[0];
        end
    end

    assign run[CH_WD]   = ctrl_q.wd_run;
    assign run[CH_PRE]  = ctrl_q.pre_run;
    assign fsel[CH_WD]  = ctrl_q.wd_fix;
    assign fsel[CH_PRE] = ctrl_q.pre_fix;

    wdog_tick_sel #(.RATIO_W(RATIO_W), .NCH(NUM_CH)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio    (ctrl_q.ratio),
        .fix_sel  (fsel),
        .fix_tick (fix_tick),
        .tick     (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wdog_countdown #(.CNT_W(DATA_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld[c]),
            .load_val (bus_wdata),
            .run      (run[c]),
            .tick     (tick[c]),
            .cnt      (cnt[c]),
            .at_zero  (hit[c])
        );

        // Sticky flag: set on hit, written 0 clears, written 1 keeps
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q[c] <= 1'b0;
            else if (hit[c]) flag_q[c] <= 1'b1;
            else if (sts_wr) flag_q[c] <= flag_q[c] & bus_wdata[c];
        end
    end

    // Read mux
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_CTRL):   bus_rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFF_STATUS): bus_rdata = DATA_W'(flag_q);
            ADDR_W'(OFF_PRECNT): bus_rdata = cnt[CH_PRE];
            ADDR_W'(OFF_WDCNT):  bus_rdata = cnt[CH_WD];
            ADDR_W'(OFF_RSTEN):  bus_rdata = DATA_W'(rst_en_q);
            ADDR_W'(OFF_RSTMSK): bus_rdata = DATA_W'(rst_msk_q);
            default:             bus_rdata = '0;
        endcase
    end

    // Outputs
    assign expire_irq  = flag_q[CH_WD];
    assign pretime_irq = flag_q[CH_PRE];
    assign rst_req     = flag_q[CH_WD] && rst_en_q && !rst_msk_q && ctrl_q.wd_run;

    // Named views for the checker
    assign wd_count  = cnt[CH_WD];
    assign pre_count = cnt[CH_PRE];
    assign wd_run    = run[CH_WD];
    assign pre_run   = run[CH_PRE];
    assign wd_load   = ld[CH_WD];
    assign pre_load  = ld[CH_PRE];
endmodule

// File: rtl/wdog_timer_chk.sv
// Property checker for wdog_timer, attached with bind below.
module wdog_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wd_run,
    input logic        wd_load,
    input logic        pre_load,
    input logic        sts_wr,
    input logic [31:0] wd_count,
    input logic [31:0] pre_count,
    input logic        expire_irq,
    input logic        pretime_irq,
    input logic        rst_req
);
    // R3
    wd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_run && !wd_load) |=> wd_count == $past(wd_count));

    // R3
    wd_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_run && !wd_load) |=>
            (wd_count == $past(wd_count) || wd_count == $past(wd_count) - 32'd1));

    // R5
    wd_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_count == 32'd0 && !wd_load) |=> wd_count == 32'd0);

    // R5
    expiry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expire_irq) |-> $past(wd_count) == 32'd0);

    // R8
    pre_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pretime_irq) |-> $past(pre_count) == 32'd0);

    // R8
    pre_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pretime_irq && !sts_wr) |=> pretime_irq);

    // R8
    pre_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_count == 32'd0 && !pre_load) |=> pre_count == 32'd0);

    // R6
    rst_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> expire_irq);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_run      (wd_run),
    .wd_load     (wd_load),
    .pre_load    (pre_load),
    .sts_wr      (sts_wr),
    .wd_count    (wd_count),
    .pre_count   (pre_count),
    .expire_irq  (expire_irq),
    .pretime_irq (pretime_irq),
    .rst_req     (rst_req)
);

// File: tb/tb_wdog_timer.sv
// Scoreboard bench: driver tasks queue expected values, and a monitor
// on the falling edge pops and compares them.
module tb_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fix_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        expire_irq, pretime_irq, rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          pins;
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;  // 50 MHz

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .expire_irq(expire_irq), .pretime_irq(pretime_irq), .rst_req(rst_req)
    );

    // Monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t it;
            logic [31:0] got;
            it = sb_q.pop_front();
            got = it.pins ? {29'd0, rst_req, pretime_irq, expire_irq} : bus_rdata;
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(posedge clk); #2;
        bus_addr = a;
        it.pins = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Pins order: {rst_req, pretime_irq, expire_irq}
    task automatic chk_pins(input logic [2:0] e, input string tag);
        exp_t it;
        @(posedge clk); #2;
        it.pins = 1'b1; it.exp = {29'd0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic finish_run();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] a;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        chk_reg(8'h00, 32'h0, "R1 ctrl");
        chk_reg(8'h04, 32'h0, "R1 status");
        chk_reg(8'h0C, 32'hFFFF_FFFF, "R1 wd count");
        chk_reg(8'h08, 32'hFFFF_FFFF, "R1 pre count");
        chk_reg(8'h10, 32'h0, "R1 rst enable");
        chk_pins(3'b000, "R1 pins");

        // R2 load while stopped, R3 no count while stopped
        wr(8'h0C, 32'd100);
        repeat (5) @(posedge clk);
        chk_reg(8'h0C, 32'd100, "R2 R3 load held while stopped");

        // R3 run at ratio 0: one per clock
        wr(8'h00, 32'h1);
        chk_reg(8'h0C, 32'd99, "R3 first decrement");
        chk_reg(8'h0C, 32'd98, "R3 second decrement");

        // R4 keepalive reload
        wr(8'h0C, 32'd50);
        chk_reg(8'h0C, 32'd49, "R4 reload restarts");

        // R5 expiry
        wr(8'h0C, 32'd3);
        repeat (6) @(posedge clk);
        chk_reg(8'h0C, 32'd0, "R5 count held at zero");
        chk_reg(8'h04, 32'h1, "R5 expiry flag");
        chk_pins(3'b001, "R5 expire_irq, no reset while disabled");

        // R6 reset gating
        wr(8'h10, 32'h1);
        chk_pins(3'b101, "R6 reset with enable, unmasked");
        wr(8'h14, 32'h1);
        chk_pins(3'b001, "R6 masked");
        wr(8'h14, 32'h0);
        chk_pins(3'b101, "R6 unmasked again");
        wr(8'h00, 32'h0);
        chk_pins(3'b001, "R6 watchdog stopped");

        // R7 clear expiry
        wr(8'h00, 32'h1);
        wr(8'h0C, 32'd1000);
        wr(8'h04, 32'h0);
        chk_reg(8'h04, 32'h0, "R7 expiry cleared");
        chk_pins(3'b000, "R7 irq low after clear");

        // R8 pretimeout
        wr(8'h00, 32'h3);
        wr(8'h08, 32'd5);
        repeat (8) @(posedge clk);
        chk_reg(8'h04, 32'h2, "R8 pretimeout flag only");
        chk_pins(3'b010, "R8 pretime_irq");
        wr(8'h00, 32'h1);
        wr(8'h04, 32'h2);
        chk_reg(8'h04, 32'h2, "R7 write one keeps flag");
        chk_pins(3'b010, "R8 irq held until cleared");
        wr(8'h04, 32'h0);
        chk_reg(8'h04, 32'h0, "R7 pretimeout cleared");
        chk_reg(8'h08, 32'd0, "R8 pre count held at zero");

        // R9 ratio 2: 16 ticks per 64 clocks
        wr(8'h00, 32'h21);
        wr(8'h0C, 32'd1000);
        rd(8'h0C, a);
        repeat (63) @(posedge clk);
        chk_reg(8'h0C, a - 32'd16, "R9 ratio 2 decrement count");

        // R10 fixed source
        wr(8'h00, 32'h25);
        rd(8'h0C, a);
        repeat (20) @(posedge clk);
        chk_reg(8'h0C, a, "R10 no tick without fix_tick");
        @(posedge clk); #2 fix_tick = 1'b1;
        repeat (5) @(posedge clk);
        #2 fix_tick = 1'b0;
        chk_reg(8'h0C, a - 32'd5, "R10 one decrement per fix_tick");
        chk_reg(8'h04, 32'h0, "R10 no flag");

        done = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule